// File: doc/BRIEF.md
# Hardware Over-Temperature Limit Comparator

This block holds four signed 8-bit over-temperature limits and checks each completed temperature conversion against them. Two limits belong to the on-die sensor. The other two are shared by both remote diode readings. Each remote reading is compared against each of the two shared limits on its own. If any reading on a conversion lies strictly above an applicable limit, the hardware-error flag is raised. The flag then holds until the next conversion.

The first on-die limit and the first remote limit can each be protected against rewriting by a lock bit. Software can set a lock bit but cannot clear it. The locks are released only by a re-initialise pulse or by the asynchronous reset. A re-initialise also restores every limit to its default and clears the flag.

Limits are written through a simple strobe port and read back combinationally. Interrupt aggregation is handled elsewhere.

Top module: `hw_temp_limit_cmp`

## Requirements
- R1: After reset, every limit register reads 127 (0x7F), both locks are clear and `hw_err_o` is 0.
- R2: A write with `wr_en_i` high to an unlocked address updates that limit, and the new value is visible on `rd_data_o` after the clock edge. Address map: 0 = on-die limit A (lockable by lock bit 0), 1 = remote limit A (lockable by lock bit 1), 2 = on-die limit B, 3 = remote limit B.
- R3: On a conversion (`conv_done_i` high), `hw_err_o` becomes 1 in the following cycle if the on-die reading is strictly greater than limit 0 or limit 2. A reading equal to a limit does not raise it.
- R4: Each remote reading is compared on its own against both remote limits (addresses 1 and 3). Either reading exceeding either limit raises `hw_err_o`.
- R5: All readings and limits are two's-complement signed 8-bit values.
- R6: `hw_err_o` changes only on a conversion or a re-initialise. A conversion with no exceedance clears it.
- R7: Once lock bit k (k = 0, 1) is set by `lock_set_i[k]`, writes to address k are ignored and read-back returns the old value. Addresses 2 and 3 never lock.
- R8: Lock bits are set-only. Holding `lock_set_i` low never clears them.
- R9: A `reinit_i` pulse clears both locks, restores all limits to 127 and clears `hw_err_o`. It takes priority over a write, a lock set or a conversion in the same cycle.
- R10: A conversion is compared against the limit values held before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Limit write strobe |
| wr_addr_i | input | 2 | Limit write address |
| wr_data_i | input | 8 | Limit write data (signed) |
| rd_addr_i | input | 2 | Limit read address |
| rd_data_o | output | 8 | Limit read data |
| lock_set_i | input | 2 | Set-only lock requests for addresses 0 and 1 |
| reinit_i | input | 1 | Re-initialise pulse |
| conv_done_i | input | 1 | Conversion-complete strobe |
| temp_int_i | input | 8 | On-die temperature reading (signed) |
| temp_ext1_i | input | 8 | First remote diode reading (signed) |
| temp_ext2_i | input | 8 | Second remote diode reading (signed) |
| hw_err_o | output | 1 | Hardware over-temperature flag |

## Verification
A write or lock request takes effect at the clock edge at which it is sampled. Because read-back is combinational, `rd_data_o` shows the result in the same cycle that follows that edge. `hw_err_o` is registered, so it reflects a conversion one edge after `conv_done_i` is sampled. The bench drives all inputs on the falling edge and samples outputs on the next falling edge, so every check falls exactly one rising edge after its stimulus. Hold and set-only behaviour is checked a few cycles later with no strobe asserted.

// File: rtl/hwtl_pkg.sv
package hwtl_pkg;
  localparam int TW       = 8;
  localparam int N_LIM    = 4;
  localparam int N_LOCK   = 2;
  localparam int N_SENS   = 3;
  localparam int AW       = $clog2(N_LIM);
  localparam logic [TW-1:0] LIM_RST = 8'h7F;

  typedef logic signed [TW-1:0] temp_t;

  // limit ownership: even addresses on-die, odd addresses remote
  localparam logic [N_LIM-1:0] INT_MASK = 4'b0101;
  localparam logic [N_LIM-1:0] EXT_MASK = 4'b1010;
endpackage

// File: rtl/hwtl_limit_bank.sv
module hwtl_limit_bank
  import hwtl_pkg::*;
#(
  parameter int NL = N_LIM,
  parameter int NK = N_LOCK,
  parameter int W  = TW,
  parameter int A  = AW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [A-1:0]         wr_addr_i,
  input  logic [W-1:0]         wr_data_i,
  input  logic [NK-1:0]        lock_set_i,
  input  logic                 reinit_i,
  output logic [NL-1:0][W-1:0] lim_o,
  output logic [NK-1:0]        lock_o
);
  logic [NK-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lock_q <= '0;
    else if (reinit_i) lock_q <= '0;
    else               lock_q <= lock_q | lock_set_i;
  end

  for (genvar k = 0; k < NL; k++) begin : g_lim
    logic locked;
    logic [W-1:0] q;
    if (k < NK) begin : g_lk
      assign locked = lock_q[k];
    end else begin : g_nl
      assign locked = 1'b0;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= LIM_RST;
      else if (reinit_i) q <= LIM_RST;
      else if (wr_en_i && wr_addr_i == A'(k) && !locked) q <= wr_data_i;
    end
    assign lim_o[k] = q;
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/hwtl_cmp.sv
module hwtl_cmp
  import hwtl_pkg::*;
#(
  parameter int NL = N_LIM,
  parameter int W  = TW,
  parameter logic [NL-1:0] SEL = '1
) (
  input  logic [W-1:0]         temp_i,
  input  logic [NL-1:0][W-1:0] lim_i,
  output logic                 over_o
);
  logic [NL-1:0] hit;
  for (genvar k = 0; k < NL; k++) begin : g_c
    if (SEL[k]) begin : g_on
      assign hit[k] = $signed(temp_i) > $signed(lim_i[k]);
    end else begin : g_off
      assign hit[k] = 1'b0;
    end
  end
  assign over_o = |hit;
endmodule

// File: rtl/hwtl_flag.sv
module hwtl_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reinit_i,
  input  logic conv_done_i,
  input  logic over_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_o <= 1'b0;
    else if (reinit_i)    flag_o <= 1'b0;
    else if (conv_done_i) flag_o <= over_i;
  end
endmodule

// File: rtl/hw_temp_limit_cmp.sv
module hw_temp_limit_cmp
  import hwtl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [TW-1:0]     wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [TW-1:0]     rd_data_o,
  input  logic [N_LOCK-1:0] lock_set_i,
  input  logic              reinit_i,
  input  logic              conv_done_i,
  input  logic [TW-1:0]     temp_int_i,
  input  logic [TW-1:0]     temp_ext1_i,
  input  logic [TW-1:0]     temp_ext2_i,
  output logic              hw_err_o
);
  logic [N_LIM-1:0][TW-1:0] lim;
  logic [N_LOCK-1:0]        lock;
  logic [N_SENS-1:0][TW-1:0] rd_temp;
  logic [N_SENS-1:0]         over;

  hwtl_limit_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .lock_set_i (lock_set_i),
    .reinit_i   (reinit_i),
    .lim_o      (lim),
    .lock_o     (lock)
  );

  assign rd_temp = {temp_ext2_i, temp_ext1_i, temp_int_i};

  // sensor 0 is on-die, the rest are remote diodes
  for (genvar s = 0; s < N_SENS; s++) begin : g_s
    hwtl_cmp #(.SEL(s == 0 ? INT_MASK : EXT_MASK)) u_cmp (
      .temp_i (rd_temp[s]),
      .lim_i  (lim),
      .over_o (over[s])
    );
  end

  hwtl_flag u_flag (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reinit_i    (reinit_i),
    .conv_done_i (conv_done_i),
    .over_i      (|over),
    .flag_o      (hw_err_o)
  );

  assign rd_data_o = lim[rd_addr_i];
endmodule

// File: rtl/hwtl_checker.sv
module hwtl_checker
  import hwtl_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    reinit_i,
  input logic                    conv_done_i,
  input logic [TW-1:0]           temp_int_i,
  input logic [N_LIM-1:0][TW-1:0] lim,
  input logic [N_LOCK-1:0]       lock,
  input logic                    hw_err_o
);
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_done_i && !reinit_i) |=> $stable(hw_err_o)); // R6

  AST_REINIT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |=> (!hw_err_o && lock == '0)); // R9

  AST_INT_DETECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_done_i && !reinit_i && $signed(temp_int_i) > $signed(lim[0])) |=> hw_err_o); // R3

  for (genvar k = 0; k < N_LOCK; k++) begin : g_k
    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock[k] && !reinit_i) |=> lock[k]); // R8
    AST_LOCKED_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock[k] && !reinit_i) |=> $stable(lim[k])); // R7
  end
endmodule

bind hw_temp_limit_cmp hwtl_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reinit_i    (reinit_i),
  .conv_done_i (conv_done_i),
  .temp_int_i  (temp_int_i),
  .lim         (lim),
  .lock        (lock),
  .hw_err_o    (hw_err_o)
);

// File: tb/sim_hw_temp_limit_cmp.sv
module sim_hw_temp_limit_cmp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] lock_set = '0;
  logic       reinit = 1'b0;
  logic       conv = 1'b0;
  logic [7:0] t_int = '0, t_e1 = '0, t_e2 = '0;
  logic       hw_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hw_temp_limit_cmp u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .lock_set_i(lock_set), .reinit_i(reinit), .conv_done_i(conv),
    .temp_int_i(t_int), .temp_ext1_i(t_e1), .temp_ext2_i(t_e2),
    .hw_err_o(hw_err)
  );

  // limits during the table: int A=50, ext A=60, int B=45, ext B=55
  // entry = {int, ext1, ext2, expected}
  localparam logic [24:0] VEC [8] = '{
    {8'sd45,   8'sd55,   8'sd55,   1'b0}, // R3 R4 equal is not over
    {8'sd46,   8'sd0,    8'sd0,    1'b1}, // R3 above int B
    {8'sd44,   8'sd56,   8'sd0,    1'b1}, // R4 ext1 above ext B
    {8'sd44,   8'sd0,    8'sd56,   1'b1}, // R4 ext2 above ext B
    {-8'sd5,   -8'sd128, -8'sd1,   1'b0}, // R5 negatives below
    {8'sd44,   8'sd55,   8'sd55,   1'b0}, // R6 clears
    {8'sd127,  8'sd127,  8'sd127,  1'b1}, // R5 max
    {-8'sd128, -8'sd128, -8'sd128, 1'b0}  // R5 min
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a; #0.5;
    chk(req, rd_data, exp);
  endtask

  task automatic cv(input logic [7:0] i, input logic [7:0] e1, input logic [7:0] e2);
    conv = 1; t_int = i; t_e1 = e1; t_e2 = e2;
    @(negedge clk);
    conv = 0;
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) rd_chk("R1", 2'(a), 8'h7F);
    chk("R1", {7'd0, hw_err}, 8'd0);

    // R2 program limits
    wr(2'd0, 8'd50); wr(2'd1, 8'd60); wr(2'd2, 8'd45); wr(2'd3, 8'd55);
    rd_chk("R2", 2'd0, 8'd50); rd_chk("R2", 2'd1, 8'd60);
    rd_chk("R2", 2'd2, 8'd45); rd_chk("R2", 2'd3, 8'd55);

    foreach (VEC[n]) begin
      cv(VEC[n][24:17], VEC[n][16:9], VEC[n][8:1]);
      chk($sformatf("R3/R4/R5 vec%0d", n), {7'd0, hw_err}, {7'd0, VEC[n][0]});
    end

    // R6 hold without conversion
    cv(8'sd100, 8'sd0, 8'sd0);
    t_int = 8'sd0;
    repeat (3) @(negedge clk);
    chk("R6 hold", {7'd0, hw_err}, 8'd1);
    cv(8'sd0, 8'sd0, 8'sd0);
    chk("R6 clear", {7'd0, hw_err}, 8'd0);

    // R7 locks
    lock_set = 2'b01; @(negedge clk); lock_set = 2'b00;
    wr(2'd0, 8'd10);
    rd_chk("R7 locked 0", 2'd0, 8'd50);
    wr(2'd1, 8'd11);
    rd_chk("R7 unlocked 1", 2'd1, 8'd11);
    wr(2'd2, 8'd12);
    rd_chk("R7 addr2 free", 2'd2, 8'd12);
    lock_set = 2'b10; @(negedge clk); lock_set = 2'b00;
    wr(2'd1, 8'd20);
    rd_chk("R7 locked 1", 2'd1, 8'd11);
    wr(2'd3, 8'd21);
    rd_chk("R7 addr3 free", 2'd3, 8'd21);
    // R8 set-only
    repeat (4) @(negedge clk);
    wr(2'd0, 8'd30);
    rd_chk("R8 sticky", 2'd0, 8'd50);

    // R9 reinit beats same-cycle write, lock and conversion
    cv(8'sd100, 8'sd0, 8'sd0);
    reinit = 1; wr_en = 1; wr_addr = 2'd0; wr_data = 8'd5; lock_set = 2'b11;
    conv = 1; t_int = 8'sd100;
    @(negedge clk);
    reinit = 0; wr_en = 0; lock_set = 0; conv = 0;
    chk("R9 flag", {7'd0, hw_err}, 8'd0);
    for (int a = 0; a < 4; a++) rd_chk("R9 default", 2'(a), 8'h7F);
    wr(2'd0, 8'd40);
    rd_chk("R9 unlocked", 2'd0, 8'd40);

    // R10 compare uses pre-write limit
    wr(2'd0, 8'd127);
    wr_en = 1; wr_addr = 2'd0; wr_data = 8'd10;
    conv = 1; t_int = 8'sd100;
    @(negedge clk);
    wr_en = 0; conv = 0;
    chk("R10 old limit", {7'd0, hw_err}, 8'd0);
    cv(8'sd100, 8'sd0, 8'sd0);
    chk("R10 new limit", {7'd0, hw_err}, 8'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule